// File: doc/BRIEF.md
# Pending and In-Service Interrupt Vector Tracker

This block holds two 256-entry bit sets for interrupt vectors. The first set records requests that have arrived but have not been taken. The second set records vectors that the processor is handling now. Each set is stored as eight 32-bit words. A single operation port accepts one command per cycle, selected by a 3-bit code and an 8-bit vector number. The commands set or clear one bit in either set, acknowledge the highest pending request, or retire the highest in-service vector.

For each set, the block keeps a registered report of the highest-numbered vector that is set. An empty set reports 0, which cannot be told apart from vector 0 alone. Hit outputs test the bit that the operation port currently addresses. A word-wide read port returns any word of either set without side effects. Comparison against a task priority and delivery to a core are handled elsewhere.

Top module: `vt_tracker`

## Requirements
- R1: While rst is high on a clock edge, every bit of both sets becomes 0, and req_top and svc_top become 0.
- R2: When op_valid is 1 and op_code is 1, the request bit for op_vec is set. Code 3 sets the in-service bit for op_vec in the same way.
- R3: Code 2 clears the request bit for op_vec, and code 4 clears the in-service bit for op_vec. Bits that are not addressed keep their value.
- R4: Vector bits [7:5] select the word and bits [4:0] select the bit inside that word. With rd_sel 0, rd_data shows request word rd_word; with rd_sel 1, it shows in-service word rd_word. Bit n of rd_data is vector rd_word*32+n.
- R5: req_top and svc_top each equal word*32 plus the position of the highest set bit in the highest nonzero word of their set. An empty set reports 0.
- R6: req_top and svc_top are registered. They take the new value on the same clock edge that applies the operation, and they do not change before that edge.
- R7: Code 5 (acknowledge) clears the highest set request bit and sets the same vector in the in-service set, in one edge. When the request set is empty, code 5 changes nothing.
- R8: Code 6 (end of interrupt) clears the highest set in-service bit. When the in-service set is empty, code 6 changes nothing.
- R9: req_hit and svc_hit show, without a clock delay, the current request and in-service bits addressed by op_vec.
- R10: Codes 0 and 7 leave both sets unchanged. Any code with op_valid low also leaves both sets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | 0 none, 1 set req, 2 clear req, 3 set svc, 4 clear svc, 5 acknowledge, 6 end of interrupt, 7 none |
| op_vec | input | 8 | Vector addressed by the operation and by the hit outputs |
| req_hit | output | 1 | Current request bit for op_vec |
| svc_hit | output | 1 | Current in-service bit for op_vec |
| rd_sel | input | 1 | Read set select: 0 request, 1 in-service |
| rd_word | input | 3 | Read word index |
| rd_data | output | 32 | Selected word |
| req_top | output | 8 | Highest set request vector, 0 when empty |
| svc_top | output | 8 | Highest set in-service vector, 0 when empty |

## Verification
An operation driven at a falling edge takes effect at the next rising edge. req_top, svc_top and both sets therefore carry the result from that edge on. The bench samples them one nanosecond after the edge and compares them with a bit-level reference model of both sets. One check samples req_top before the edge, to confirm that it still holds the old value while the operation is waiting. The hit outputs and rd_data are combinational views of the stored sets. They are read after the edge that wrote the sets, with a short settle delay after rd_sel or rd_word changes.

// File: rtl/vt_pkg.sv
package vt_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_SET_REQ = 3'd1,
        OP_CLR_REQ = 3'd2,
        OP_SET_SVC = 3'd3,
        OP_CLR_SVC = 3'd4,
        OP_ACK     = 3'd5,
        OP_EOI     = 3'd6,
        OP_RSVD    = 3'd7
    } vt_op_e;

    typedef struct packed {
        logic set_req;
        logic clr_req;
        logic set_svc;
        logic clr_svc;
        logic ack;
        logic eoi;
    } vt_ctl_t;

    function automatic vt_ctl_t vt_decode(input logic valid, input logic [2:0] code);
        vt_ctl_t c;
        c = '0;
        if (valid) begin
            case (vt_op_e'(code))
                OP_SET_REQ: c.set_req = 1'b1;
                OP_CLR_REQ: c.clr_req = 1'b1;
                OP_SET_SVC: c.set_svc = 1'b1;
                OP_CLR_SVC: c.clr_svc = 1'b1;
                OP_ACK:     c.ack     = 1'b1;
                OP_EOI:     c.eoi     = 1'b1;
                default:    c         = '0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/vt_bitset.sv
module vt_bitset #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int TOTAL = WORDS * WORD_W,
    localparam int VEC_W = $clog2(TOTAL),
    localparam int BIT_W = $clog2(WORD_W),
    localparam int IDX_W = VEC_W - BIT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [VEC_W-1:0] set_vec,
    input  logic             clr_en,
    input  logic [VEC_W-1:0] clr_vec,
    output logic [TOTAL-1:0] bits_q,
    output logic [TOTAL-1:0] bits_d
);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic [WORD_W-1:0] word_d;
        logic              set_here;
        logic              clr_here;

        assign set_here = set_en && (set_vec[VEC_W-1:BIT_W] == IDX_W'(w));
        assign clr_here = clr_en && (clr_vec[VEC_W-1:BIT_W] == IDX_W'(w));

        always_comb begin
            word_d = word_q;
            if (set_here) word_d[set_vec[BIT_W-1:0]] = 1'b1;
            if (clr_here) word_d[clr_vec[BIT_W-1:0]] = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst) word_q <= '0;
            else     word_q <= word_d;
        end

        assign bits_q[w*WORD_W +: WORD_W] = word_q;
        assign bits_d[w*WORD_W +: WORD_W] = word_d;
    end

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (set_en && !(clr_en && clr_vec == set_vec)) |=> bits_q[$past(set_vec)]);

    assert_clr_lands_R3: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> !bits_q[$past(clr_vec)]);

endmodule

// File: rtl/vt_top_scan.sv
module vt_top_scan #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int TOTAL = WORDS * WORD_W,
    localparam int VEC_W = $clog2(TOTAL),
    localparam int BIT_W = $clog2(WORD_W)
) (
    input  logic [TOTAL-1:0] bits,
    output logic [VEC_W-1:0] top,
    output logic             any
);

    logic [WORDS-1:0] nz;
    logic [BIT_W-1:0] pos [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word;
        assign word  = bits[w*WORD_W +: WORD_W];
        assign nz[w] = |word;

        always_comb begin
            pos[w] = '0;
            for (int i = 0; i < WORD_W; i++) begin
                if (word[i]) pos[w] = BIT_W'(i);
            end
        end
    end

    always_comb begin
        top = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (nz[w]) top = VEC_W'(w * WORD_W) + VEC_W'(pos[w]);
        end
    end

    assign any = |nz;

endmodule

// File: rtl/vt_tracker.sv
module vt_tracker
    import vt_pkg::*;
#(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int TOTAL = WORDS * WORD_W,
    localparam int VEC_W = $clog2(TOTAL),
    localparam int BIT_W = $clog2(WORD_W),
    localparam int IDX_W = VEC_W - BIT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [VEC_W-1:0]  op_vec,
    output logic              req_hit,
    output logic              svc_hit,
    input  logic              rd_sel,
    input  logic [IDX_W-1:0]  rd_word,
    output logic [WORD_W-1:0] rd_data,
    output logic [VEC_W-1:0]  req_top,
    output logic [VEC_W-1:0]  svc_top
);

    vt_ctl_t ctl;
    assign ctl = vt_decode(op_valid, op_code);

    logic [TOTAL-1:0] req_q, req_d, svc_q, svc_d;
    logic [VEC_W-1:0] req_top_q, svc_top_q, req_top_d, svc_top_d;
    logic             req_any_q, svc_any_q, req_any_d, svc_any_d;

    logic             do_ack, do_eoi;
    logic             req_set_en, req_clr_en, svc_set_en, svc_clr_en;
    logic [VEC_W-1:0] req_clr_vec, svc_set_vec, svc_clr_vec;

    assign do_ack = ctl.ack && req_any_q;
    assign do_eoi = ctl.eoi && svc_any_q;

    assign req_set_en  = ctl.set_req;
    assign req_clr_en  = ctl.clr_req || do_ack;
    assign req_clr_vec = do_ack ? req_top_q : op_vec;
    assign svc_set_en  = ctl.set_svc || do_ack;
    assign svc_set_vec = do_ack ? req_top_q : op_vec;
    assign svc_clr_en  = ctl.clr_svc || do_eoi;
    assign svc_clr_vec = do_eoi ? svc_top_q : op_vec;

    vt_bitset #(.WORDS(WORDS), .WORD_W(WORD_W)) u_req (
        .clk(clk), .rst(rst),
        .set_en(req_set_en), .set_vec(op_vec),
        .clr_en(req_clr_en), .clr_vec(req_clr_vec),
        .bits_q(req_q), .bits_d(req_d)
    );

    vt_bitset #(.WORDS(WORDS), .WORD_W(WORD_W)) u_svc (
        .clk(clk), .rst(rst),
        .set_en(svc_set_en), .set_vec(svc_set_vec),
        .clr_en(svc_clr_en), .clr_vec(svc_clr_vec),
        .bits_q(svc_q), .bits_d(svc_d)
    );

    vt_top_scan #(.WORDS(WORDS), .WORD_W(WORD_W)) u_req_scan (
        .bits(req_d), .top(req_top_d), .any(req_any_d)
    );

    vt_top_scan #(.WORDS(WORDS), .WORD_W(WORD_W)) u_svc_scan (
        .bits(svc_d), .top(svc_top_d), .any(svc_any_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_top_q <= '0;
            svc_top_q <= '0;
            req_any_q <= 1'b0;
            svc_any_q <= 1'b0;
        end else begin
            req_top_q <= req_top_d;
            svc_top_q <= svc_top_d;
            req_any_q <= req_any_d;
            svc_any_q <= svc_any_d;
        end
    end

    assign req_top = req_top_q;
    assign svc_top = svc_top_q;
    assign req_hit = req_q[op_vec];
    assign svc_hit = svc_q[op_vec];

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (rd_word == IDX_W'(w))
                rd_data = rd_sel ? svc_q[w*WORD_W +: WORD_W] : req_q[w*WORD_W +: WORD_W];
        end
    end

    // The reported top must point at a set bit whenever the set is not empty.
    assert_req_top_set_R5: assert property (@(posedge clk) disable iff (rst)
        req_any_q |-> req_q[req_top_q]);
    assert_svc_top_set_R5: assert property (@(posedge clk) disable iff (rst)
        svc_any_q |-> svc_q[svc_top_q]);
    assert_req_empty_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (req_q == '0) |-> (req_top_q == '0));

    assert_ack_moves_R7: assert property (@(posedge clk) disable iff (rst)
        do_ack |=> (svc_q[$past(req_top_q)] && !req_q[$past(req_top_q)]));
    assert_ack_empty_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl.ack && !req_any_q) |=> ($stable(svc_q) && $stable(req_q)));

    assert_eoi_clears_R8: assert property (@(posedge clk) disable iff (rst)
        do_eoi |=> !svc_q[$past(svc_top_q)]);
    assert_eoi_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl.eoi && !svc_any_q) |=> $stable(svc_q));

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (ctl == '0) |=> ($stable(req_q) && $stable(svc_q)));

endmodule

// File: tb/tb_vt_tracker.sv
`timescale 1ns/1ps
module tb_vt_tracker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [7:0]  op_vec = 8'd0;
    logic        req_hit, svc_hit;
    logic        rd_sel = 1'b0;
    logic [2:0]  rd_word = 3'd0;
    logic [31:0] rd_data;
    logic [7:0]  req_top, svc_top;

    always #2.5 clk = ~clk;

    vt_tracker dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_vec(op_vec),
        .req_hit(req_hit), .svc_hit(svc_hit), .rd_sel(rd_sel), .rd_word(rd_word),
        .rd_data(rd_data), .req_top(req_top), .svc_top(svc_top)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [255:0] ref_req = '0;
    logic [255:0] ref_svc = '0;

    function automatic logic [7:0] ref_top(input logic [255:0] s);
        logic [7:0] t = 8'd0;
        for (int i = 0; i < 256; i++) if (s[i]) t = 8'(i);
        return t;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] code, input logic [7:0] vec, input logic valid);
        logic [7:0] t;
        @(negedge clk);
        op_valid = valid; op_code = code; op_vec = vec;
        if (valid) begin
            case (code)
                3'd1: ref_req[vec] = 1'b1;
                3'd2: ref_req[vec] = 1'b0;
                3'd3: ref_svc[vec] = 1'b1;
                3'd4: ref_svc[vec] = 1'b0;
                3'd5: if (ref_req != '0) begin
                          t = ref_top(ref_req); ref_req[t] = 1'b0; ref_svc[t] = 1'b1;
                      end
                3'd6: if (ref_svc != '0) begin
                          t = ref_top(ref_svc); ref_svc[t] = 1'b0;
                      end
                default: ;
            endcase
        end
        @(posedge clk); #1;
        op_valid = 1'b0;
        chk("R5 req_top", 32'(req_top), 32'(ref_top(ref_req)));
        chk("R5 svc_top", 32'(svc_top), 32'(ref_top(ref_svc)));
    endtask

    task automatic check_words(input string tag);
        for (int s = 0; s < 2; s++) begin
            for (int w = 0; w < 8; w++) begin
                rd_sel = s[0]; rd_word = 3'(w); #0.2;
                chk(tag, rd_data, s == 0 ? ref_req[w*32 +: 32] : ref_svc[w*32 +: 32]);
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 req_top", 32'(req_top), 0);
        chk("R1 svc_top", 32'(svc_top), 0);
        check_words("R1 words");
        @(negedge clk); rst = 1'b0;

        // R2 / R6 / R9: ascending sweep of request sets, top tracks each new vector
        for (int v = 0; v < 256; v++) begin
            do_op(3'd1, 8'(v), 1'b1);
            chk("R2 req_top", 32'(req_top), 32'(v));
            chk("R9 req_hit", 32'(req_hit), 1);
        end
        check_words("R4 full words");

        // R6: output must not move before the edge that applies the operation
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd2; op_vec = 8'd255;
        ref_req[255] = 1'b0;
        #1 chk("R6 before edge", 32'(req_top), 255);
        @(posedge clk); #1; op_valid = 1'b0;
        chk("R6 after edge", 32'(req_top), 254);

        // R3 / R4: descending clears, checking the word holding each vector
        for (int v = 254; v >= 0; v--) begin
            do_op(3'd2, 8'(v), 1'b1);
            chk("R3 req_top", 32'(req_top), v == 0 ? 0 : 32'(v - 1));
            chk("R9 req_hit", 32'(req_hit), 0);
            rd_sel = 1'b0; rd_word = 3'(v >> 5); #0.2;
            chk("R4 word", rd_data, ref_req[(v >> 5)*32 +: 32]);
        end

        // R4: single-bit placement in in-service words
        for (int v = 0; v < 256; v += 37) begin
            do_op(3'd3, 8'(v), 1'b1);
            chk("R9 svc_hit", 32'(svc_hit), 1);
            rd_sel = 1'b1; rd_word = 3'(v >> 5); #0.2;
            chk("R4 svc bit", 32'(rd_data[v % 32]), 1);
            do_op(3'd4, 8'(v), 1'b1);
            chk("R3 svc clear", 32'(svc_top), 0);
        end

        // R5: scattered in-service pattern
        do_op(3'd3, 8'd3, 1'b1);
        do_op(3'd3, 8'd200, 1'b1);
        do_op(3'd3, 8'd40, 1'b1);
        chk("R5 svc_top", 32'(svc_top), 200);
        do_op(3'd4, 8'd200, 1'b1);
        chk("R5 svc_top after clear", 32'(svc_top), 40);
        do_op(3'd4, 8'd40, 1'b1);
        do_op(3'd4, 8'd3, 1'b1);
        chk("R5 empty svc", 32'(svc_top), 0);

        // R10: idle codes and strobe low change nothing
        do_op(3'd1, 8'd99, 1'b1);
        do_op(3'd0, 8'd12, 1'b1);
        do_op(3'd7, 8'd12, 1'b1);
        do_op(3'd1, 8'd150, 1'b0);
        do_op(3'd5, 8'd0, 1'b0);
        chk("R10 req_top", 32'(req_top), 99);
        check_words("R10 words");
        do_op(3'd2, 8'd99, 1'b1);

        // R7: acknowledge moves highest pending into service
        do_op(3'd1, 8'd5, 1'b1);
        do_op(3'd1, 8'd180, 1'b1);
        do_op(3'd1, 8'd37, 1'b1);
        do_op(3'd1, 8'd64, 1'b1);
        do_op(3'd5, 8'd0, 1'b1);
        chk("R7 svc_top", 32'(svc_top), 180);
        chk("R7 req_top", 32'(req_top), 64);
        do_op(3'd5, 8'd0, 1'b1);
        do_op(3'd5, 8'd0, 1'b1);
        do_op(3'd5, 8'd0, 1'b1);
        chk("R7 req empty", 32'(req_top), 0);
        check_words("R7 words");
        do_op(3'd5, 8'd0, 1'b1);
        chk("R7 empty ack svc_top", 32'(svc_top), 180);
        check_words("R7 empty ack words");

        // R8: end of interrupt retires in descending order
        do_op(3'd6, 8'd0, 1'b1);
        chk("R8 svc_top", 32'(svc_top), 64);
        do_op(3'd6, 8'd0, 1'b1);
        chk("R8 svc_top", 32'(svc_top), 37);
        do_op(3'd6, 8'd0, 1'b1);
        do_op(3'd6, 8'd0, 1'b1);
        chk("R8 svc empty", 32'(svc_top), 0);
        do_op(3'd1, 8'd7, 1'b1);
        do_op(3'd6, 8'd0, 1'b1);
        chk("R8 empty eoi req kept", 32'(req_top), 7);
        check_words("R8 words");

        // R1: reset with contents present
        do_op(3'd3, 8'd250, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        ref_req = '0; ref_svc = '0;
        chk("R1 req_top again", 32'(req_top), 0);
        chk("R1 svc_top again", 32'(svc_top), 0);
        check_words("R1 words again");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule